// File: doc/BRIEF.md
# Fractional Baud Divisor Search Engine

This engine chooses the settings of a fractional baud-rate generator. Given a reference clock frequency and a wanted baud rate, it walks through every legal pair of fractional multiplier and fractional add value. For each pair it runs a long division in fixed point and rounds the quotient to the nearest integer divisor. It keeps the pair whose rate error is smallest and reports the integer divisor, multiplier and add value with a single-cycle done pulse.

The generator divides the reference by sixteen times the integer divisor, then scales the rate by mul/(mul+divadd). For each candidate the engine therefore computes the quotient (F << 28) * mul / ((mul + divadd) * B) to 64 bits. The upper 32 bits form the integer divisor and the lower 32 bits form the fraction that serves as the error. The search is sequential and uses one restoring divider, so a candidate costs a fixed number of cycles. The engine stops as soon as a candidate matches exactly. Loading the chosen values into the generator is left to the surrounding logic.

Top module: `baud_search`

## Requirements
- R1: Candidates are visited with mul rising from 1 to 15 in the outer loop and divadd rising from 0 to mul-1 in the inner loop, 120 pairs in all. When two candidates have equal error, the one visited first is kept.
- R2: For each candidate the quotient Q = floor((F * 2^28 * mul) / ((mul + divadd) * B)) is formed exactly to 64 bits. The raw divisor is Q[63:32] and the raw error is Q[31:0].
- R3: If the raw error is strictly above 2^31, the divisor is increased by one and the error becomes 2^32 minus the raw error. A raw error of exactly 2^31 leaves both unchanged.
- R4: A candidate is legal only when its rounded divisor lies in 1 to 65536 inclusive. A reported divisor is never outside that range.
- R5: The best error starts each search at 2^32-1. A legal candidate replaces the kept one only when its error is strictly smaller.
- R6: The search ends at the first kept candidate whose error is zero, and no later candidate is examined.
- R7: Each examined candidate takes 66 cycles. done_o rises for exactly one cycle, 66*N cycles after the clock edge that accepted start_i, where N is the number of candidates examined.
- R8: When no candidate is legal, done_o comes with no_fit_o=1 and dl_o, mul_o and divadd_o all 0.
- R9: freq_i and baud_i are captured on the edge that accepts start_i. Later changes on them, and start_i pulses while a search runs, have no effect on that search.
- R10: After reset all outputs are 0. dl_o, mul_o, divadd_o and no_fit_o change only in the cycle where done_o is high and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a search when the engine is idle |
| freq_i | input | IN_W | Reference clock frequency in Hz |
| baud_i | input | IN_W | Target baud rate, must be nonzero |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| no_fit_o | output | 1 | Set with done_o when no legal divisor exists |
| dl_o | output | 17 | Chosen integer divisor |
| mul_o | output | 4 | Chosen fractional multiplier |
| divadd_o | output | 4 | Chosen fractional add value |

## Verification
Each stimulus pattern separates a different part of the search. A reference that is an exact multiple of sixteen times the baud stops at the first candidate. A reference whose ideal divisor ends in exactly one half checks the non-rounding boundary, keeps the tied earliest pair, and then exits on a later exact fraction. A typical crystal/baud pair exercises rounding up across the full walk. The divisor limits are probed with an exact 65536 and with 65537, which forces a fractional pair. Too slow a reference and too fast a reference must both report no fit after all 120 pairs. A search whose inputs are disturbed in the middle must return the result for the captured inputs, and every cycle the done timing and the held outputs are compared against a behavioural model.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;

    localparam int BSR_MUL_MAX = 15;
    localparam int BSR_MUL_W   = $clog2(BSR_MUL_MAX + 1);
    localparam int BSR_DL_MAX  = 65536;
    localparam int BSR_DL_W    = $clog2(BSR_DL_MAX + 1);

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_DIV,
        S_EVAL
    } bsr_state_e;

    typedef struct packed {
        logic [BSR_DL_W-1:0]  dl;
        logic [BSR_MUL_W-1:0] mul;
        logic [BSR_MUL_W-1:0] divadd;
    } bsr_pick_t;

    function automatic logic [BSR_MUL_W:0] bsr_sum(input logic [BSR_MUL_W-1:0] m,
                                                   input logic [BSR_MUL_W-1:0] d);
        return {1'b0, m} + {1'b0, d};
    endfunction

endpackage

// File: rtl/bsr_cand_seq.sv
module bsr_cand_seq
    import baud_search_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 first_i,
    input  logic                 advance_i,
    output logic [BSR_MUL_W-1:0] mul_o,
    output logic [BSR_MUL_W-1:0] divadd_o,
    output logic                 last_o
);
    localparam logic [BSR_MUL_W-1:0] MUL_TOP = BSR_MUL_W'(BSR_MUL_MAX);

    logic [BSR_MUL_W-1:0] mul_q;
    logic [BSR_MUL_W-1:0] divadd_q;

    always_ff @(posedge clk) begin
        if (rst || first_i) begin
            mul_q    <= BSR_MUL_W'(1);
            divadd_q <= '0;
        end else if (advance_i) begin
            if (divadd_q == mul_q - BSR_MUL_W'(1)) begin
                mul_q    <= mul_q + BSR_MUL_W'(1);
                divadd_q <= '0;
            end else begin
                divadd_q <= divadd_q + BSR_MUL_W'(1);
            end
        end
    end

    assign mul_o    = mul_q;
    assign divadd_o = divadd_q;
    assign last_o   = (mul_q == MUL_TOP) && (divadd_q == MUL_TOP - BSR_MUL_W'(1));

    AST_MUL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (mul_q >= BSR_MUL_W'(1)) && (mul_q <= MUL_TOP)); // R1
    AST_DIVADD_BELOW_MUL: assert property (@(posedge clk) disable iff (rst)
        divadd_q < mul_q); // R1
    AST_NO_ADVANCE_PAST_LAST: assert property (@(posedge clk) disable iff (rst)
        (advance_i && !first_i && !last_o) |=> (mul_q >= $past(mul_q))); // R1

endmodule

// File: rtl/bsr_divider.sv
module bsr_divider #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 37
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             last_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W:0]   rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    logic [DEN_W:0] shifted;
    logic [DEN_W:0] diff;
    logic           fits;

    always_comb begin
        shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
        fits    = shifted >= {1'b0, den_q};
        diff    = shifted - {1'b0, den_q};
    end

    assign last_o = run_q && (cnt_q == CNT_W'(NUM_W - 1));
    assign quo_o  = quo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            quo_q <= num_i;
            rem_q <= '0;
            den_q <= den_i;
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            quo_q <= {quo_q[NUM_W-2:0], fits};
            rem_q <= fits ? diff : shifted;
            cnt_q <= cnt_q + CNT_W'(1);
            if (last_o) begin
                run_q <= 1'b0;
            end
        end
    end

    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
        (run_q && (den_q != '0)) |-> (rem_q < {1'b0, den_q})); // R2
    AST_LOAD_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !run_q); // R7

endmodule

// File: rtl/bsr_judge.sv
module bsr_judge
    import baud_search_pkg::*;
#(
    parameter int QUO_W  = 64,
    parameter int FRAC_W = 32
) (
    input  logic [QUO_W-1:0]    quo_i,
    output logic                ok_o,
    output logic [FRAC_W-1:0]   err_o,
    output logic [BSR_DL_W-1:0] dl_o
);
    localparam int INT_W = QUO_W - FRAC_W;
    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

    logic [INT_W:0]    whole;
    logic [INT_W:0]    rounded;
    logic [FRAC_W-1:0] frac;
    logic              up;

    always_comb begin
        whole   = {1'b0, quo_i[QUO_W-1:FRAC_W]};
        frac    = quo_i[FRAC_W-1:0];
        up      = frac > HALF;
        rounded = whole + (INT_W + 1)'(up);
        err_o   = up ? (~frac + FRAC_W'(1)) : frac;
        ok_o    = (rounded != '0) && (rounded <= (INT_W + 1)'(BSR_DL_MAX));
        dl_o    = BSR_DL_W'(rounded);
    end

endmodule

// File: rtl/bsr_best.sv
module bsr_best
    import baud_search_pkg::*;
#(
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             eval_i,
    input  logic             ok_i,
    input  logic [ERR_W-1:0] err_i,
    input  bsr_pick_t        pick_i,
    output logic             take_o,
    output logic [ERR_W-1:0] best_err_o,
    output bsr_pick_t        best_pick_o,
    output logic             have_o
);
    logic [ERR_W-1:0] best_err_q;
    bsr_pick_t        best_pick_q;
    logic             have_q;

    assign take_o      = eval_i && ok_i && (err_i < best_err_q);
    assign best_err_o  = best_err_q;
    assign best_pick_o = best_pick_q;
    assign have_o      = have_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            best_err_q  <= '1;
            best_pick_q <= '0;
            have_q      <= 1'b0;
        end else if (take_o) begin
            best_err_q  <= err_i;
            best_pick_q <= pick_i;
            have_q      <= 1'b1;
        end
    end

    AST_BEST_NONINCREASING: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (best_err_q <= $past(best_err_q))); // R5
    AST_KEPT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        have_q |-> ((best_pick_q.dl != '0) && (best_pick_q.dl <= BSR_DL_W'(BSR_DL_MAX)))); // R4

endmodule

// File: rtl/baud_search.sv
module baud_search
    import baud_search_pkg::*;
#(
    parameter int IN_W     = 32,
    parameter int FRAC_W   = 32,
    parameter int OVS_LOG2 = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [IN_W-1:0]      freq_i,
    input  logic [IN_W-1:0]      baud_i,
    output logic                 done_o,
    output logic                 no_fit_o,
    output logic [BSR_DL_W-1:0]  dl_o,
    output logic [BSR_MUL_W-1:0] mul_o,
    output logic [BSR_MUL_W-1:0] divadd_o
);
    localparam int SHIFT = FRAC_W - OVS_LOG2;
    localparam int NUM_W = IN_W + SHIFT + BSR_MUL_W;
    localparam int DEN_W = IN_W + BSR_MUL_W + 1;

    bsr_state_e state_q;
    logic [IN_W-1:0] freq_q;
    logic [IN_W-1:0] baud_q;
    logic            done_q;
    logic            nofit_q;
    bsr_pick_t       res_q;

    logic [BSR_MUL_W-1:0] mul;
    logic [BSR_MUL_W-1:0] divadd;
    logic                 last_cand;
    logic                 first;
    logic                 advance;

    logic [NUM_W-1:0]    num;
    logic [DEN_W-1:0]    den;
    logic                div_last;
    logic [NUM_W-1:0]    quo;

    logic                cand_ok;
    logic [FRAC_W-1:0]   cand_err;
    logic [BSR_DL_W-1:0] cand_dl;
    bsr_pick_t           cand_pick;

    logic                take;
    logic [FRAC_W-1:0]   best_err;
    bsr_pick_t           best_pick;
    logic                have;

    logic                accept;
    logic                eval;
    logic                finish;
    logic                fin_have;
    bsr_pick_t           fin_pick;

    always_comb begin
        accept    = (state_q == S_IDLE) && start_i;
        eval      = (state_q == S_EVAL);
        first     = accept;
        finish    = eval && ((take && (cand_err == '0)) || last_cand);
        advance   = eval && !finish;
        num       = (NUM_W'(freq_q) << SHIFT) * NUM_W'(mul);
        den       = DEN_W'(bsr_sum(mul, divadd)) * DEN_W'(baud_q);
        cand_pick = '{dl: cand_dl, mul: mul, divadd: divadd};
        fin_have  = have || take;
        fin_pick  = take ? cand_pick : best_pick;
    end

    bsr_cand_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .first_i  (first),
        .advance_i(advance),
        .mul_o    (mul),
        .divadd_o (divadd),
        .last_o   (last_cand)
    );

    bsr_divider #(
        .NUM_W(NUM_W),
        .DEN_W(DEN_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .load_i(state_q == S_LOAD),
        .num_i (num),
        .den_i (den),
        .last_o(div_last),
        .quo_o (quo)
    );

    bsr_judge #(
        .QUO_W (NUM_W),
        .FRAC_W(FRAC_W)
    ) u_judge (
        .quo_i(quo),
        .ok_o (cand_ok),
        .err_o(cand_err),
        .dl_o (cand_dl)
    );

    bsr_best #(
        .ERR_W(FRAC_W)
    ) u_best (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (accept),
        .eval_i     (eval),
        .ok_i       (cand_ok),
        .err_i      (cand_err),
        .pick_i     (cand_pick),
        .take_o     (take),
        .best_err_o (best_err),
        .best_pick_o(best_pick),
        .have_o     (have)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            freq_q  <= '0;
            baud_q  <= '0;
            done_q  <= 1'b0;
            nofit_q <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        freq_q  <= freq_i;
                        baud_q  <= baud_i;
                        state_q <= S_LOAD;
                    end
                end
                S_LOAD: state_q <= S_DIV;
                S_DIV: begin
                    if (div_last) begin
                        state_q <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    if (finish) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                        nofit_q <= !fin_have;
                        res_q   <= fin_have ? fin_pick : '0;
                    end else begin
                        state_q <= S_LOAD;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign done_o   = done_q;
    assign no_fit_o = nofit_q;
    assign dl_o     = res_q.dl;
    assign mul_o    = res_q.mul;
    assign divadd_o = res_q.divadd;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R7
    AST_NOFIT_ZEROED: assert property (@(posedge clk) disable iff (rst)
        (done_q && nofit_q) |-> (res_q == '0)); // R8
    AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (done_q && !nofit_q) |-> ((res_q.dl != '0) && (res_q.dl <= BSR_DL_W'(BSR_DL_MAX)))); // R4
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> ($stable(res_q) && $stable(nofit_q))); // R10
    AST_INPUTS_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE) |=> ($stable(freq_q) && $stable(baud_q))); // R9
    AST_EXACT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (eval && take && (cand_err == '0)) |=> (state_q == S_IDLE)); // R6
    AST_BEST_NOT_ZERO_MIDRUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LOAD) |-> (best_err != '0)); // R6

endmodule

// File: tb/baud_search_tb.sv
module baud_search_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] freq;
    logic [31:0] baud;
    logic        done;
    logic        nofit;
    logic [16:0] dl;
    logic [3:0]  mul;
    logic [3:0]  divadd;

    int checks = 0;
    int bad    = 0;

    logic [16:0] p_dl;
    logic [3:0]  p_mul;
    logic [3:0]  p_divadd;
    logic        p_nofit;

    always #5 clk = ~clk;

    baud_search u_dut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .freq_i  (freq),
        .baud_i  (baud),
        .done_o  (done),
        .no_fit_o(nofit),
        .dl_o    (dl),
        .mul_o   (mul),
        .divadd_o(divadd)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void ref_search(input logic [31:0] f, input logic [31:0] b,
                                       output logic [16:0] r_dl, output logic [3:0] r_mul,
                                       output logic [3:0] r_div, output logic r_nf,
                                       output int n);
        logic [31:0] best;
        bit          stop;
        best  = 32'hFFFF_FFFF;
        stop  = 0;
        n     = 0;
        r_dl  = '0;
        r_mul = '0;
        r_div = '0;
        r_nf  = 1'b1;
        for (int m = 1; m <= 15; m++) begin
            for (int d = 0; d < m; d++) begin
                logic [63:0] nm;
                logic [63:0] dn;
                logic [63:0] q;
                logic [32:0] ip;
                logic [31:0] er;
                if (!stop) begin
                    n++;
                    nm = (64'(f) << 28) * 64'(m);
                    dn = 64'(m + d) * 64'(b);
                    q  = nm / dn;
                    ip = {1'b0, q[63:32]};
                    er = q[31:0];
                    if (er > 32'h8000_0000) begin
                        er = 32'd0 - er;
                        ip = ip + 33'd1;
                    end
                    if (ip >= 33'd1 && ip <= 33'd65536 && er < best) begin
                        best  = er;
                        r_dl  = ip[16:0];
                        r_mul = 4'(m);
                        r_div = 4'(d);
                        r_nf  = 1'b0;
                        if (er == 32'd0) stop = 1;
                    end
                end
            end
        end
    endfunction

    task automatic run(input logic [31:0] f, input logic [31:0] b, input string req,
                       input bit disturb);
        logic [16:0] e_dl;
        logic [3:0]  e_mul;
        logic [3:0]  e_div;
        logic        e_nf;
        int          n;
        int          lat;
        ref_search(f, b, e_dl, e_mul, e_div, e_nf, n);
        lat = n * 66;
        @(negedge clk);
        freq  = f;
        baud  = b;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            freq = f ^ 32'h00F0_0F0F;
            baud = b + 32'd777;
        end
        chk("R7 done low after start", 64'(done), 64'd0);
        for (int j = 1; j <= lat; j++) begin
            if (disturb && j == 20) start = 1'b1;
            if (disturb && j == 21) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (j < lat) begin
                chk("R7 done early", 64'(done), 64'd0);
                chk("R10 dl held", 64'(dl), 64'(p_dl));
                chk("R10 mul held", 64'(mul), 64'(p_mul));
                chk("R10 divadd held", 64'(divadd), 64'(p_divadd));
                chk("R10 nofit held", 64'(nofit), 64'(p_nofit));
            end else begin
                chk("R7 done at 66*N", 64'(done), 64'd1);
                chk({req, " dl"}, 64'(dl), 64'(e_dl));
                chk({req, " mul"}, 64'(mul), 64'(e_mul));
                chk({req, " divadd"}, 64'(divadd), 64'(e_div));
                chk({req, " no_fit"}, 64'(nofit), 64'(e_nf));
            end
        end
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7 done one cycle", 64'(done), 64'd0);
        p_dl     = e_dl;
        p_mul    = e_mul;
        p_divadd = e_div;
        p_nofit  = e_nf;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        freq  = '0;
        baud  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset done", 64'(done), 64'd0);
        chk("R10 reset dl", 64'(dl), 64'd0);
        chk("R10 reset mul", 64'(mul), 64'd0);
        chk("R10 reset divadd", 64'(divadd), 64'd0);
        chk("R10 reset nofit", 64'(nofit), 64'd0);
        p_dl = '0; p_mul = '0; p_divadd = '0; p_nofit = 1'b0;

        run(32'd15_360_000, 32'd9600, "R6 exact first", 1'b0);
        run(32'd1_608_000, 32'd1000, "R3 half not rounded", 1'b0);
        run(32'd12_000_000, 32'd115200, "R2 general", 1'b0);
        run(32'd16_040_000, 32'd1000, "R1 tie order", 1'b0);
        run(32'd10_485_760, 32'd10, "R4 top divisor", 1'b0);
        run(32'd10_485_920, 32'd10, "R4 above top", 1'b0);
        run(32'd1000, 32'd1_000_000, "R8 too slow", 1'b0);
        run(32'd4_000_000_000, 32'd1, "R8 too fast", 1'b0);
        run(32'd48_000_000, 32'd57600, "R9 disturbed", 1'b1);
        run(32'd204_000_000, 32'd921600, "R5 strict best", 1'b0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule